// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the transmit half of one asynchronous serial channel. Software places a character into a single-entry holding register. A shift stage then frames the character and sends it one bit per baud tick. The frame is a low start bit, seven or eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The baud tick comes from outside the block.

Two flags are visible at the ports. The first shows that the holding register carries a character that has not yet been taken. The second shows that a frame is on the line. Software can load the next character while the current one is still shifting out, so consecutive frames follow each other with no idle gap. A one-cycle completion pulse marks the end of each frame.

One configuration byte selects the framing and gates the whole channel. Clearing either enable bit stops the channel at once.

Top module: `sertx_core`

## Requirements
- R1: The channel is enabled only while configuration bit 7 (clock enable) and bit 6 (transmit enable) are both 1. When either bit is 0, the next clock edge aborts any frame, drives `txd` high and clears `buf_full` and `shift_busy`. While disabled, writes are ignored.
- R2: When the channel is enabled and `buf_full` is 0, a one-cycle `wr_stb` stores `wr_data` and sets `buf_full` at that clock edge.
- R3: A write while `buf_full` is 1 is ignored. The held character is neither replaced nor sent.
- R4: On a `baud_tick`, when `buf_full` is 1 and the shifter is idle or is ending its last bit, the character moves into the shifter. At that edge `buf_full` clears, `shift_busy` sets and `txd` goes low for the start bit.
- R5: After the start bit, each later `baud_tick` puts the next frame bit on `txd`. The data bits follow the start bit LSB first. Configuration bit 2 = 1 sends 8 data bits; bit 2 = 0 sends bits 6:0 only. Configuration bit 1 = 1 sends two stop bits; bit 1 = 0 sends one. Stop bits are high.
- R6: Configuration bits 4:3 choose the parity bit that follows the data bits. 00 sends no parity bit. 01 sends a 0. 10 sends odd parity, so the count of ones in data plus parity is odd. 11 sends even parity.
- R7: The `baud_tick` that ends the last stop bit raises `tx_irq` for exactly one cycle. If no new character is taken at that edge, it also clears `shift_busy`.
- R8: Whenever `shift_busy` is 0, `txd` is high. If a character is waiting when a frame ends, its start bit follows the last stop bit with no idle bit between them.
- R9: After a synchronous active-low reset, `txd` is 1, and `buf_full`, `shift_busy` and `tx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle bit-period strobe |
| cfg | input | 8 | Configuration byte |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| buf_full | output | 1 | Holding register has an unsent character |
| shift_busy | output | 1 | A frame is being shifted out |
| tx_irq | output | 1 | One-cycle frame-complete pulse |

## Verification
Every result is registered. `buf_full` reflects a write one edge after the strobe. The start bit, the cleared `buf_full` and the set `shift_busy` all appear at the edge that samples the loading tick. Each later frame bit appears at the edge that samples its own tick. `tx_irq` shows at the edge of the tick after the last stop bit. An enable drop takes effect at the next edge. The bench holds each strobe for exactly one cycle starting at a falling edge. It reads the outputs at the following falling edge, when that single rising edge has updated them, and it checks every bit position of each frame that way.

// File: rtl/sertx_pkg.sv
// Shared definitions for the buffered serial transmitter.
// Assumes a byte-wide character and a frame of at most 12 bits.
package sertx_pkg;
    localparam int CHAR_W  = 8;
    localparam int FRAME_W = 1 + CHAR_W + 1 + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic      clk_on;
        logic      tx_on;
        logic      rsvd5;
        par_mode_e par;
        logic      len8;
        logic      stop2;
        logic      rsvd0;
    } cfg_t;
endpackage

// File: rtl/sertx_framer.sv
// Combinational frame builder. It turns a character and the configuration
// into a line pattern (bit 0 goes out first, unused upper bits are 1) and
// the number of bit periods in the frame.
module sertx_framer
    import sertx_pkg::*;
(
    input  cfg_t               cfg,
    input  logic [CHAR_W-1:0]  data,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   flen
);
    logic [CHAR_W-1:0] used;
    logic              pbit;
    int                pidx;

    // Build the pattern and its length for the selected framing.
    always_comb begin
        used  = cfg.len8 ? data : {1'b0, data[CHAR_W-2:0]};
        pbit  = 1'b0;
        frame = '1;
        frame[0] = 1'b0;
        if (cfg.len8) begin
            frame[CHAR_W:1] = data;
            pidx = CHAR_W + 1;
        end else begin
            frame[CHAR_W-1:1] = data[CHAR_W-2:0];
            pidx = CHAR_W;
        end
        case (cfg.par)
            PAR_ZERO: pbit = 1'b0;
            PAR_ODD:  pbit = ~(^used);
            PAR_EVEN: pbit = ^used;
            default:  pbit = 1'b1;
        endcase
        if (cfg.par != PAR_NONE) frame[pidx] = pbit;
        flen = LEN_W'(1 + (cfg.len8 ? CHAR_W : CHAR_W - 1)
                        + ((cfg.par != PAR_NONE) ? 1 : 0)
                        + (cfg.stop2 ? 2 : 1));
    end
endmodule

// File: rtl/sertx_holdbuf.sv
// Single-entry holding register. It accepts a write only when it is empty
// and the channel runs, and it empties when the shifter takes the character.
// Assumes that take is raised only while full is set.
module sertx_holdbuf
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] data
);
    // Track occupancy and capture accepted characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!run) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
// Frame shifter. It sends one pattern bit per baud tick, reports activity
// and pulses done on the tick that ends the last bit. A pending character
// is taken on that same tick so frames run back to back.
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               baud_tick,
    input  logic               pending,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   flen,
    output logic               take,
    output logic               txd,
    output logic               busy,
    output logic               done
);
    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left_q;
    logic               last;

    assign last = (left_q == '0);
    // Load when a character waits and the shifter is free or finishing.
    assign take = run && baud_tick && pending && (!busy || last);

    // Advance the line one bit per tick, or restart with a new pattern.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sh_q   <= '1;
            left_q <= '0;
            busy   <= 1'b0;
            txd    <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= baud_tick && busy && last;
            if (take) begin
                txd    <= frame[0];
                sh_q   <= {1'b1, frame[FRAME_W-1:1]};
                left_q <= flen - LEN_W'(1);
                busy   <= 1'b1;
            end else if (baud_tick && busy) begin
                if (last) begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end else begin
                    txd    <= sh_q[0];
                    sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                    left_q <= left_q - LEN_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sertx_core.sv
// Buffered serial transmitter top. It ties the holding register, the frame
// builder and the shifter together. The configuration is sampled when a
// character enters the shifter. Assumes baud_tick is a one-cycle strobe.
module sertx_core
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [7:0] cfg,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       buf_full,
    output logic       shift_busy,
    output logic       tx_irq
);
    cfg_t               cfg_s;
    logic               run;
    logic               take;
    logic [CHAR_W-1:0]  hold_data;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   flen;

    assign cfg_s = cfg_t'(cfg);
    assign run   = cfg_s.clk_on && cfg_s.tx_on;

    sertx_holdbuf i_hold (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_stb(wr_stb),
        .wr_data(wr_data), .take(take), .full(buf_full), .data(hold_data)
    );

    sertx_framer i_frm (
        .cfg(cfg_s), .data(hold_data), .frame(frame), .flen(flen)
    );

    sertx_shifter i_shf (
        .clk(clk), .rst_n(rst_n), .run(run), .baud_tick(baud_tick),
        .pending(buf_full), .frame(frame), .flen(flen), .take(take),
        .txd(txd), .busy(shift_busy), .done(tx_irq)
    );
endmodule

// File: rtl/sertx_core_chk.sv
// Property checker for sertx_core, attached by bind. It observes the ports
// and the held character only.
module sertx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg,
    input logic       txd,
    input logic       buf_full,
    input logic       shift_busy,
    input logic       tx_irq,
    input logic [7:0] hold_data
);
    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg[7] && cfg[6]) |=> (!buf_full && !shift_busy && txd));

    p_full_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && $past(buf_full)) |-> $stable(hold_data));

    p_take_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(buf_full) && $past(cfg[7] && cfg[6])) |-> (shift_busy && !txd));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_irq_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(shift_busy));

    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_busy |-> txd);
endmodule

bind sertx_core sertx_core_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .txd(txd), .buf_full(buf_full),
    .shift_busy(shift_busy), .tx_irq(tx_irq), .hold_data(hold_data)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, buf_full, shift_busy, tx_irq;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    sertx_core i_sertx_core (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg(cfg),
        .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd), .buf_full(buf_full),
        .shift_busy(shift_busy), .tx_irq(tx_irq)
    );

    // {cfg, data, expected frame bits (bit 0 first), frame length}
    localparam logic [31:0] VEC [6] = '{
        {8'hC4, 8'hA5, 12'h34A, 4'd10},
        {8'hDC, 8'h07, 12'h60E, 4'd11},
        {8'hD2, 8'h81, 12'h602, 4'd11},
        {8'hCC, 8'hFF, 12'h5FE, 4'd11},
        {8'hC0, 8'h55, 12'h1AA, 4'd9},
        {8'hDA, 8'h03, 12'h606, 4'd11}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); baud_tick = 1'b1;
        @(negedge clk); baud_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(txd && !buf_full && !shift_busy && !tx_irq, "R9 reset state",
              {txd, buf_full, shift_busy, tx_irq}, 4'b1000);
        rst_n = 1'b1;
        cfg = 8'hC4;

        // Vector table: one full frame per entry.
        foreach (VEC[v]) begin
            logic [7:0]  vcfg = VEC[v][31:24];
            logic [7:0]  vdat = VEC[v][23:16];
            logic [11:0] vexp = VEC[v][15:4];
            int          vlen = int'(VEC[v][3:0]);
            @(negedge clk); cfg = vcfg;
            write_char(vdat);
            check(buf_full, "R2 write sets buffer flag", buf_full, 1);
            for (int k = 0; k < vlen; k++) begin
                tick();
                if (k == 0)
                    check(shift_busy && !buf_full, "R4 load moves buffer",
                          {shift_busy, buf_full}, 2'b10);
                check(txd == vexp[k], $sformatf("R5 R6 frame %0d bit %0d", v, k),
                      txd, vexp[k]);
            end
            tick();
            check(tx_irq && !shift_busy && txd, "R7 completion pulse",
                  {tx_irq, shift_busy, txd}, 3'b101);
            @(negedge clk);
            check(!tx_irq, "R7 pulse one cycle", tx_irq, 0);
        end

        // Write while full is ignored.
        @(negedge clk); cfg = 8'hC4;
        write_char(8'h0F);
        write_char(8'hF0);
        tick();
        tick();
        check(txd == 1'b1, "R3 held character kept (bit0=1)", txd, 1);
        for (int k = 0; k < 8; k++) tick();
        check(txd == 1'b1 && shift_busy, "R3 stop bit", txd, 1);
        tick();
        check(!shift_busy && !buf_full, "R3 second write dropped",
              {shift_busy, buf_full}, 2'b00);

        // Back-to-back frames, no gap.
        write_char(8'h00);
        tick();
        write_char(8'hFF);
        check(buf_full && shift_busy, "R8 double buffered", {buf_full, shift_busy}, 2'b11);
        for (int k = 1; k < 10; k++) tick();
        check(txd == 1'b1, "R8 first stop bit", txd, 1);
        tick();
        check(tx_irq && !txd && shift_busy && !buf_full, "R8 start follows stop",
              {tx_irq, txd, shift_busy, buf_full}, 4'b1010);
        tick();
        check(txd == 1'b1, "R8 second frame data", txd, 1);

        // Abort by clearing transmit enable, with a character waiting.
        write_char(8'h00);
        @(negedge clk); cfg = 8'h84;
        @(negedge clk);
        check(txd && !shift_busy && !buf_full, "R1 abort on tx enable",
              {txd, shift_busy, buf_full}, 3'b100);

        // Write with clock enable off is ignored.
        @(negedge clk); cfg = 8'h44;
        write_char(8'h00);
        check(!buf_full, "R1 write ignored when disabled", buf_full, 0);
        @(negedge clk); cfg = 8'hC4;
        tick();
        check(txd && !shift_busy && !buf_full, "R1 nothing sent after re-enable",
              {txd, shift_busy, buf_full}, 3'b100);

        // Abort by clearing clock enable mid-frame.
        write_char(8'h00);
        tick();
        check(!txd, "R4 start bit low", txd, 0);
        @(negedge clk); cfg = 8'h44;
        @(negedge clk);
        check(txd && !shift_busy, "R1 abort on clock enable", {txd, shift_busy}, 2'b10);

        // Reset mid-frame.
        @(negedge clk); cfg = 8'hC4;
        write_char(8'h00);
        tick();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(txd && !buf_full && !shift_busy && !tx_irq, "R9 reset mid-frame",
              {txd, buf_full, shift_busy, tx_irq}, 4'b1000);
        rst_n = 1'b1;

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule